// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block turns one read or write request at a time into the pin sequence an asynchronous SRAM or NOR-style device expects. A request carries an address, write data, byte enables and a direction flag. The sequencer drives chip select, output enable, write enable, active-low byte-lane enables, the address bus and a data bus that is split into an output value, an output enable and an input value. When multiplexing is enabled for a device type that allows it, the data bus carries the address first.

Each phase of the access lasts a number of clock cycles taken from configuration inputs. Reads use one set of counts. Writes may use a second set of their own. The byte lanes can be enabled some cycles before chip select falls. A turnaround gap follows every access before the next request is taken. A wait input with selectable active level can stall the strobe phase. It has an effect only when wait handling for asynchronous accesses is switched on. The data bus runs 16 bits wide, or 8 bits with the upper byte lane parked.

The configuration inputs are expected to stay constant while an access is in flight.

Top module: `sram_async_seq`

## Requirements
- R1: After a request is taken, the access runs these phases in this order: lane lead, address setup, address hold, strobe, data hold, turnaround. The lengths are the lane-setup, address-setup, address-hold, strobe and data-hold counts. A count of zero skips its phase, except the strobe, which lasts at least one cycle. Chip select is low, active, from address setup to the end of data hold.
- R2: The address hold phase appears only when `cfg_mux_en` and `cfg_dev_muxable` are both 1. In that case the low address bits drive the data bus, with `mem_dq_oe` at 1, during address setup and address hold. Otherwise no address hold phase is inserted and the data bus is not driven before the strobe.
- R3: The byte-lane enables `mem_be_n` (bit i low means lane i is active) go active `cfg_lane_setup` cycles before chip select falls and stay active until chip select rises. In idle and turnaround they are all high.
- R4: `req_ready` is high only in idle. After chip select rises it stays low for the turnaround count. A request held valid while the sequencer is busy does not start a new access.
- R5: When `cfg_wr_sep` is 1, write accesses take their address setup, address hold, strobe, data hold and turnaround counts from the `wr_*` inputs. Reads, and writes with `cfg_wr_sep` at 0, take them from the `rd_*` inputs.
- R6: The wait input is active when it is high and `cfg_wait_pol_hi` is 1, or when it is low and `cfg_wait_pol_hi` is 0.
- R7: When `cfg_async_wait_en` is 0, the wait input has no effect on the length of the strobe.
- R8: When wait handling is enabled, each strobe cycle that ends with wait active adds one cycle to the strobe.
- R9: `rsp_done` pulses high for exactly one cycle: the cycle after the last strobe cycle. For a read, `rsp_rdata` then holds the `mem_dq_in` value sampled at the end of that last strobe cycle.
- R10: When `cfg_bus8` is 1, `mem_be_n[1]` stays high. Bits 15:8 of `mem_dq_out` and of the captured read data are zero.
- R11: During the strobe, a read drives `mem_oe_n` low, keeps `mem_we_n` high and does not drive the data bus. A write drives `mem_we_n` low, keeps `mem_oe_n` high, and drives `mem_dq_out` with the write data through the strobe and data hold. `mem_addr` holds the request address while chip select is low.
- R12: After reset, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and every bit of `mem_be_n` are high, `mem_dq_oe` and `rsp_done` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus8 | input | 1 | 1 selects the 8-bit data bus, 0 the 16-bit bus |
| cfg_mux_en | input | 1 | Request address/data multiplexing |
| cfg_dev_muxable | input | 1 | Attached device type allows multiplexing |
| cfg_wr_sep | input | 1 | Writes use the write timing set |
| cfg_wait_pol_hi | input | 1 | Wait input active high when 1 |
| cfg_async_wait_en | input | 1 | Honour the wait input |
| cfg_lane_setup | input | CNT_W | Cycles of byte-lane lead before chip select |
| rd_aset | input | CNT_W | Read address setup cycles |
| rd_ahld | input | CNT_W | Read address hold cycles |
| rd_dset | input | CNT_W | Read strobe cycles |
| rd_dhld | input | CNT_W | Read data hold cycles |
| rd_turn | input | CNT_W | Read turnaround cycles |
| wr_aset | input | CNT_W | Write address setup cycles |
| wr_ahld | input | CNT_W | Write address hold cycles |
| wr_dset | input | CNT_W | Write strobe cycles |
| wr_dhld | input | CNT_W | Write data hold cycles |
| wr_turn | input | CNT_W | Write turnaround cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq_out | output | DATA_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | DATA_W | Data bus input value |
| mem_wait | input | 1 | Device wait input |

## Verification
The bench builds the block with its defaults: 16-bit address, 16-bit data and 4-bit phase counters. With these values every count from zero to fifteen can be applied, and one build covers both the 16-bit mode and the 8-bit mode with its parked upper lane. Because the counters are short, whole accesses take only a few dozen cycles. Many random combinations of phase lengths, directions, multiplexing, timing-set choice and wait patterns therefore fit in one run, beside directed cases for all-zero counts, a device type that refuses multiplexing, both wait polarities, ignored wait and a request held during a busy access.

// File: rtl/sram_async_pkg.sv
// Shared types for the asynchronous static memory sequencer.
// Holds the phase encoding and the rule that picks the next present phase.
// Assumes the strobe phase is always present (length at least one).
package sram_async_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LANE = 3'd1,
        PH_ASET = 3'd2,
        PH_AHLD = 3'd3,
        PH_DSET = 3'd4,
        PH_DHLD = 3'd5,
        PH_TURN = 3'd6
    } phase_e;

    // Next phase after cur, skipping phases whose length is zero.
    function automatic phase_e step_after(
        input phase_e cur,
        input logic   lane_nz,
        input logic   aset_nz,
        input logic   ahld_on,
        input logic   dhld_nz,
        input logic   turn_nz
    );
        phase_e nxt;
        case (cur)
            PH_IDLE: nxt = lane_nz ? PH_LANE : aset_nz ? PH_ASET : ahld_on ? PH_AHLD : PH_DSET;
            PH_LANE: nxt = aset_nz ? PH_ASET : ahld_on ? PH_AHLD : PH_DSET;
            PH_ASET: nxt = ahld_on ? PH_AHLD : PH_DSET;
            PH_AHLD: nxt = PH_DSET;
            PH_DSET: nxt = dhld_nz ? PH_DHLD : turn_nz ? PH_TURN : PH_IDLE;
            PH_DHLD: nxt = turn_nz ? PH_TURN : PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sram_wait_qual.sv
// Wait qualifier: turns the raw device wait level into a strobe stall request.
// Applies the selected polarity and the enable for asynchronous accesses.
// Assumes mem_wait is already synchronous to clk.
module sram_wait_qual (
    input  logic mem_wait,
    input  logic pol_hi,
    input  logic enable,
    input  logic in_strobe,
    output logic stall
);

    logic wait_active;

    // Map the pin level to an active flag according to the polarity.
    always_comb begin
        wait_active = pol_hi ? mem_wait : ~mem_wait;
    end

    // A stall is requested only inside the strobe and only when enabled.
    always_comb begin
        stall = enable & in_strobe & wait_active;
    end

endmodule

// File: rtl/sram_phase_ctrl.sv
// Phase controller: walks the access phases and counts cycles within each.
// Loads the remaining-cycle counter on phase entry and freezes it while the
// strobe is stalled. Assumes lengths stay stable while an access is running.
module sram_phase_ctrl
    import sram_async_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stall,
    input  logic             mux_on,
    input  logic [CNT_W-1:0] len_lane,
    input  logic [CNT_W-1:0] len_aset,
    input  logic [CNT_W-1:0] len_ahld,
    input  logic [CNT_W-1:0] len_dset,
    input  logic [CNT_W-1:0] len_dhld,
    input  logic [CNT_W-1:0] len_turn,
    output phase_e           phase,
    output logic             idle,
    output logic             strobe_last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dset_eff;
    phase_e           nxt;
    logic             at_end;

    // The strobe lasts at least one cycle even when programmed as zero.
    always_comb begin
        dset_eff = (len_dset == '0) ? ONE : len_dset;
    end

    // Length of a phase in cycles.
    function automatic logic [CNT_W-1:0] len_of(input phase_e p);
        logic [CNT_W-1:0] l;
        case (p)
            PH_LANE: l = len_lane;
            PH_ASET: l = len_aset;
            PH_AHLD: l = len_ahld;
            PH_DSET: l = dset_eff;
            PH_DHLD: l = len_dhld;
            PH_TURN: l = len_turn;
            default: l = ONE;
        endcase
        return l;
    endfunction

    // Choose the next present phase from the current one.
    always_comb begin
        nxt = step_after(phase, len_lane != '0, len_aset != '0,
                         mux_on && (len_ahld != '0), len_dhld != '0,
                         len_turn != '0);
    end

    // Flag the final cycle of the current phase.
    always_comb begin
        at_end = (phase != PH_IDLE) && (cnt == '0) && !(phase == PH_DSET && stall);
    end

    // Phase register and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase <= nxt;
                cnt   <= len_of(nxt) - ONE;
            end
        end else if (phase == PH_DSET && stall) begin
            cnt <= cnt;
        end else if (at_end) begin
            phase <= nxt;
            cnt   <= (nxt == PH_IDLE) ? '0 : len_of(nxt) - ONE;
        end else begin
            cnt <= cnt - ONE;
        end
    end

    // Status toward the request side and the pin driver.
    always_comb begin
        idle        = (phase == PH_IDLE);
        strobe_last = (phase == PH_DSET) && at_end;
    end

    AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DSET && stall) |=> (phase == PH_DSET && cnt == $past(cnt))); // R8

    AST_AHLD_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_AHLD) |-> mux_on); // R2

endmodule

// File: rtl/sram_pin_drive.sv
// Pin driver: latches the request and decodes the phase into device pins.
// Captures read data at the end of the strobe and issues the done pulse.
// Assumes DATA_W is a multiple of 8; in 8-bit mode only lane 0 is used.
module sram_pin_drive
    import sram_async_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    input  phase_e            phase,
    input  logic              strobe_last,
    input  logic              bus8,
    input  logic              mux_on,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              lat_write,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    localparam int BE_W = DATA_W / 8;

    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [BE_W-1:0]   lat_be;
    logic [DATA_W-1:0] dmask;
    logic [BE_W-1:0]   lmask;
    logic              cs_on;
    logic              lanes_on;
    logic              addr_on_dq;
    logic              wdata_on_dq;

    // Lane and data masks for the selected bus width.
    always_comb begin
        dmask = bus8 ? DATA_W'(8'hFF) : '1;
        lmask = bus8 ? BE_W'(1) : '1;
    end

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
            lat_write <= 1'b0;
        end else if (start) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
            lat_write <= req_write;
        end
    end

    // Decode which phases assert which group of pins.
    always_comb begin
        cs_on       = (phase == PH_ASET) || (phase == PH_AHLD) ||
                      (phase == PH_DSET) || (phase == PH_DHLD);
        lanes_on    = cs_on || (phase == PH_LANE);
        addr_on_dq  = mux_on && ((phase == PH_ASET) || (phase == PH_AHLD));
        wdata_on_dq = lat_write && ((phase == PH_DSET) || (phase == PH_DHLD));
    end

    // Control strobes and lane enables.
    always_comb begin
        mem_cs_n = ~cs_on;
        mem_oe_n = ~((phase == PH_DSET) && !lat_write);
        mem_we_n = ~((phase == PH_DSET) && lat_write);
        mem_be_n = lanes_on ? ~(lat_be & lmask) : '1;
        mem_addr = lat_addr;
    end

    // Data bus: address in the multiplexed phases, write data in strobe and hold.
    always_comb begin
        if (addr_on_dq) begin
            mem_dq_oe  = 1'b1;
            mem_dq_out = DATA_W'(lat_addr) & dmask;
        end else if (wdata_on_dq) begin
            mem_dq_oe  = 1'b1;
            mem_dq_out = lat_wdata & dmask;
        end else begin
            mem_dq_oe  = 1'b0;
            mem_dq_out = '0;
        end
    end

    // Capture read data on the last strobe cycle and pulse done one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= strobe_last;
            if (strobe_last && !lat_write) begin
                rsp_rdata <= mem_dq_in & dmask;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(phase) == PH_DSET)); // R9

endmodule

// File: rtl/sram_async_seq.sv
// Top of the asynchronous static memory sequencer.
// Takes one request at a time, picks the read or write timing set, and
// connects the wait qualifier, phase controller and pin driver.
// Assumes configuration inputs are stable while an access is running.
module sram_async_seq
    import sram_async_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_bus8,
    input  logic                cfg_mux_en,
    input  logic                cfg_dev_muxable,
    input  logic                cfg_wr_sep,
    input  logic                cfg_wait_pol_hi,
    input  logic                cfg_async_wait_en,
    input  logic [CNT_W-1:0]    cfg_lane_setup,
    input  logic [CNT_W-1:0]    rd_aset,
    input  logic [CNT_W-1:0]    rd_ahld,
    input  logic [CNT_W-1:0]    rd_dset,
    input  logic [CNT_W-1:0]    rd_dhld,
    input  logic [CNT_W-1:0]    rd_turn,
    input  logic [CNT_W-1:0]    wr_aset,
    input  logic [CNT_W-1:0]    wr_ahld,
    input  logic [CNT_W-1:0]    wr_dset,
    input  logic [CNT_W-1:0]    wr_dhld,
    input  logic [CNT_W-1:0]    wr_turn,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_cs_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in,
    input  logic                mem_wait
);

    phase_e           phase;
    logic             idle;
    logic             strobe_last;
    logic             stall;
    logic             start;
    logic             lat_write;
    logic             cur_write;
    logic             use_wset;
    logic             mux_on;
    logic [CNT_W-1:0] t_aset, t_ahld, t_dset, t_dhld, t_turn;

    // Accept a request only when idle; multiplexing needs a capable device.
    always_comb begin
        req_ready = idle;
        start     = req_valid && idle;
        mux_on    = cfg_mux_en && cfg_dev_muxable;
    end

    // Pick the timing set from the incoming or latched direction.
    always_comb begin
        cur_write = idle ? req_write : lat_write;
        use_wset  = cur_write && cfg_wr_sep;
        t_aset    = use_wset ? wr_aset : rd_aset;
        t_ahld    = use_wset ? wr_ahld : rd_ahld;
        t_dset    = use_wset ? wr_dset : rd_dset;
        t_dhld    = use_wset ? wr_dhld : rd_dhld;
        t_turn    = use_wset ? wr_turn : rd_turn;
    end

    sram_wait_qual u_wait (
        .mem_wait  (mem_wait),
        .pol_hi    (cfg_wait_pol_hi),
        .enable    (cfg_async_wait_en),
        .in_strobe (phase == PH_DSET),
        .stall     (stall)
    );

    sram_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .stall       (stall),
        .mux_on      (mux_on),
        .len_lane    (cfg_lane_setup),
        .len_aset    (t_aset),
        .len_ahld    (t_ahld),
        .len_dset    (t_dset),
        .len_dhld    (t_dhld),
        .len_turn    (t_turn),
        .phase       (phase),
        .idle        (idle),
        .strobe_last (strobe_last)
    );

    sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .phase       (phase),
        .strobe_last (strobe_last),
        .bus8        (cfg_bus8),
        .mux_on      (mux_on),
        .mem_dq_in   (mem_dq_in),
        .lat_write   (lat_write),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_be_n    (mem_be_n),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe)
    );

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready); // R4

    AST_LANE_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && cfg_lane_setup != '0) |-> ($past(phase) == PH_LANE)); // R3

endmodule

// File: tb/sram_async_seq_tb_top.sv
`timescale 1ns/1ps
module sram_async_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus8 = 0, cfg_mux_en = 0, cfg_dev_muxable = 0, cfg_wr_sep = 0;
    logic        cfg_wait_pol_hi = 0, cfg_async_wait_en = 0;
    logic [3:0]  cfg_lane_setup = 0;
    logic [3:0]  rd_aset = 0, rd_ahld = 0, rd_dset = 0, rd_dhld = 0, rd_turn = 0;
    logic [3:0]  wr_aset = 0, wr_ahld = 0, wr_dset = 0, wr_dhld = 0, wr_turn = 0;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_addr = 0, req_wdata = 0;
    logic [1:0]  req_be = 0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_addr, mem_dq_out;
    logic [15:0] mem_dq_in = 0;
    logic        mem_wait = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sram_async_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_bus8(cfg_bus8), .cfg_mux_en(cfg_mux_en), .cfg_dev_muxable(cfg_dev_muxable),
        .cfg_wr_sep(cfg_wr_sep), .cfg_wait_pol_hi(cfg_wait_pol_hi),
        .cfg_async_wait_en(cfg_async_wait_en), .cfg_lane_setup(cfg_lane_setup),
        .rd_aset(rd_aset), .rd_ahld(rd_ahld), .rd_dset(rd_dset), .rd_dhld(rd_dhld), .rd_turn(rd_turn),
        .wr_aset(wr_aset), .wr_ahld(wr_ahld), .wr_dset(wr_dset), .wr_dhld(wr_dhld), .wr_turn(wr_turn),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_strobe(input logic [3:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    // Inactive wait level for the current polarity.
    function automatic logic wait_level(input bit active);
        return cfg_wait_pol_hi ? active : !active;
    endfunction

    // One access; wmode 1 drives random wait activity; hold_v keeps valid high while busy.
    task automatic do_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                             input logic [1:0] be, input bit wmode, input bit hold_v);
        bit          use_w = wr && cfg_wr_sep;
        bit          mux   = cfg_mux_en && cfg_dev_muxable;
        logic [15:0] dmask = cfg_bus8 ? 16'h00FF : 16'hFFFF;
        logic [1:0]  ebe_n = ~(be & (cfg_bus8 ? 2'b01 : 2'b11));
        int e_aset = use_w ? int'(wr_aset) : int'(rd_aset);
        int e_ahld = use_w ? int'(wr_ahld) : int'(rd_ahld);
        int e_dset = eff_strobe(use_w ? wr_dset : rd_dset);
        int e_dhld = use_w ? int'(wr_dhld) : int'(rd_dhld);
        int e_turn = use_w ? int'(wr_turn) : int'(rd_turn);
        int n_lane = 0, n_addr = 0, n_stb = 0, n_hold = 0, n_turn = 0, stalls = 0;
        int pin_err = 0, be_err = 0, done_err = 0, rd_err = 0;
        bit seen_cs = 0, seen_stb = 0, prev_stb = 0, finished = 0;
        logic [15:0] last_dq = 0;
        string ts = use_w ? "R5" : "R1";
        string ws = wmode ? (cfg_async_wait_en ? (cfg_wait_pol_hi ? "R6" : "R8") : "R7") : ts;

        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (!hold_v) req_valid = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            bit stb_now = !mem_cs_n && (!mem_oe_n || !mem_we_n);
            bit w_act;
            if (rsp_done != (prev_stb && !stb_now)) done_err++;
            if (prev_stb && !stb_now && !wr && rsp_rdata != (last_dq & dmask)) rd_err++;
            if (req_ready) begin finished = 1; break; end
            if (mem_cs_n) begin
                if (!seen_cs) begin n_lane++; if (mem_be_n != ebe_n) be_err++; end
                else begin n_turn++; if (mem_be_n != 2'b11) be_err++; end
            end else begin
                seen_cs = 1;
                if (mem_be_n != ebe_n) be_err++;
                if (mem_addr != a) pin_err++;
                if (stb_now) begin
                    n_stb++; seen_stb = 1;
                    if (wr && !(mem_we_n == 0 && mem_oe_n == 1 && mem_dq_oe && mem_dq_out == (d & dmask))) pin_err++;
                    if (!wr && !(mem_oe_n == 0 && mem_we_n == 1 && !mem_dq_oe)) pin_err++;
                end else if (!seen_stb) begin
                    n_addr++;
                    if (mux && !(mem_dq_oe && mem_dq_out == (a & dmask))) pin_err++;
                    if (!mux && mem_dq_oe) pin_err++;
                end else begin
                    n_hold++;
                    if (wr && !(mem_dq_oe && mem_dq_out == (d & dmask))) pin_err++;
                    if (!wr && mem_dq_oe) pin_err++;
                end
            end
            w_act = wmode ? bit'($urandom_range(0, 1)) : 1'b0;
            mem_wait = wait_level(w_act);
            mem_dq_in = 16'($urandom);
            if (stb_now) last_dq = mem_dq_in;
            if (stb_now && cfg_async_wait_en && w_act) stalls++;
            prev_stb = stb_now;
            @(negedge clk);
        end
        mem_wait = wait_level(1'b0);
        chk(finished, ts, "access completes", int'(finished), 1);
        chk(n_lane == int'(cfg_lane_setup), "R3", "lane lead cycles", n_lane, int'(cfg_lane_setup));
        chk(n_addr == e_aset + (mux ? e_ahld : 0), mux ? "R2" : ts, "address cycles",
            n_addr, e_aset + (mux ? e_ahld : 0));
        chk(n_stb == e_dset + stalls, ws, "strobe cycles", n_stb, e_dset + stalls);
        chk(n_hold == e_dhld, ts, "data hold cycles", n_hold, e_dhld);
        chk(n_turn == e_turn, "R4", "turnaround cycles", n_turn, e_turn);
        chk(done_err == 0 && rd_err == 0, "R9", "done pulse / read data errors", done_err + rd_err, 0);
        chk(pin_err == 0, "R11", "strobe and bus pin errors", pin_err, 0);
        chk(be_err == 0, cfg_bus8 ? "R10" : "R3", "byte lane errors", be_err, 0);
        if (hold_v) begin
            req_valid = 1'b0;
            @(negedge clk);
            chk(req_ready && mem_cs_n && mem_be_n == 2'b11, "R4",
                "held request did not restart", int'(req_ready), 1);
        end
    endtask

    task automatic set_rd(input int a, input int h, input int s, input int dh, input int t);
        rd_aset = 4'(a); rd_ahld = 4'(h); rd_dset = 4'(s); rd_dhld = 4'(dh); rd_turn = 4'(t);
    endtask

    task automatic set_wr(input int a, input int h, input int s, input int dh, input int t);
        wr_aset = 4'(a); wr_ahld = 4'(h); wr_dset = 4'(s); wr_dhld = 4'(dh); wr_turn = 4'(t);
    endtask

    initial begin
        @(posedge clk);
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe &&
            !rsp_done && req_ready, "R12", "reset pin state", int'(mem_cs_n), 1);

        // R1 basic read and write with default configuration
        cfg_lane_setup = 1; set_rd(2, 1, 3, 1, 2);
        do_access(0, 16'h1234, 16'h0, 2'b11, 0, 0);
        do_access(1, 16'h4321, 16'hBEEF, 2'b01, 0, 0);
        // R1 all counts zero, strobe still one cycle
        cfg_lane_setup = 0; set_rd(0, 0, 0, 0, 0);
        do_access(0, 16'h0F0F, 16'h0, 2'b11, 0, 0);
        do_access(1, 16'hF0F0, 16'h5A5A, 2'b10, 0, 0);
        // R2 multiplexing on a capable device, then refused by device type
        cfg_mux_en = 1; cfg_dev_muxable = 1; cfg_lane_setup = 2; set_rd(1, 2, 2, 0, 1);
        do_access(0, 16'hA5C3, 16'h0, 2'b11, 0, 0);
        do_access(1, 16'h3C5A, 16'h1111, 2'b11, 0, 0);
        cfg_dev_muxable = 0;
        do_access(0, 16'hA5C3, 16'h0, 2'b11, 0, 0);
        cfg_mux_en = 0;
        // R5 separate write timing set
        cfg_wr_sep = 1; set_wr(3, 0, 4, 2, 3); set_rd(1, 0, 1, 1, 1);
        do_access(1, 16'h2222, 16'hCAFE, 2'b11, 0, 0);
        do_access(0, 16'h2222, 16'h0, 2'b11, 0, 0);
        cfg_wr_sep = 0;
        do_access(1, 16'h2222, 16'hCAFE, 2'b11, 0, 0);
        // R8 wait active low, R6 active high, R7 ignored when disabled
        cfg_async_wait_en = 1; cfg_wait_pol_hi = 0; mem_wait = 1'b1; set_rd(1, 0, 3, 1, 1);
        do_access(0, 16'h7777, 16'h0, 2'b11, 1, 0);
        cfg_wait_pol_hi = 1; mem_wait = 1'b0;
        do_access(0, 16'h7778, 16'h0, 2'b11, 1, 0);
        do_access(1, 16'h7779, 16'h9999, 2'b11, 1, 0);
        cfg_async_wait_en = 0;
        do_access(0, 16'h777A, 16'h0, 2'b11, 1, 0);
        cfg_wait_pol_hi = 0; mem_wait = 1'b1;
        // R10 8-bit bus
        cfg_bus8 = 1;
        do_access(1, 16'hABCD, 16'hFEDC, 2'b11, 0, 0);
        do_access(0, 16'hABCE, 16'h0, 2'b11, 0, 0);
        cfg_mux_en = 1; cfg_dev_muxable = 1; rd_ahld = 1;
        do_access(0, 16'hABCF, 16'h0, 2'b11, 0, 0);
        cfg_mux_en = 0; cfg_bus8 = 0;
        // R4 request held valid while busy
        cfg_lane_setup = 1; set_rd(1, 0, 2, 1, 3);
        do_access(0, 16'h5555, 16'h0, 2'b11, 0, 1);

        // Constrained random mix
        for (int k = 0; k < 60; k++) begin
            bit wr = bit'($urandom_range(0, 1));
            cfg_bus8 = bit'($urandom_range(0, 1));
            cfg_mux_en = bit'($urandom_range(0, 1));
            cfg_dev_muxable = bit'($urandom_range(0, 1));
            cfg_wr_sep = bit'($urandom_range(0, 1));
            cfg_wait_pol_hi = bit'($urandom_range(0, 1));
            cfg_async_wait_en = bit'($urandom_range(0, 1));
            mem_wait = wait_level(1'b0);
            cfg_lane_setup = 4'($urandom_range(0, 3));
            set_rd($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15),
                   $urandom_range(0, 3), $urandom_range(0, 4));
            set_wr($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15),
                   $urandom_range(0, 3), $urandom_range(0, 4));
            do_access(wr, 16'($urandom), 16'($urandom), 2'($urandom_range(1, 3)),
                      bit'($urandom_range(0, 1)), 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule